// File: doc/BRIEF.md
# Tributary Signaling Byte Inserter

This block builds the framing and signaling byte for each outgoing low-order tributary channel when the mapper runs in byte-synchronous mode. Each channel has a 5-bit link selector that names one framer link. From that link the block takes two phase bits, four signaling bits and a frame bit. Three enable flags per channel decide which of these fields come from the link. A field whose flag is clear takes a programmable overhead default instead. The last bit position is always a programmable fixed-stuff value.

Channel timing is time-multiplexed. A byte strobe arrives together with a channel index. In that same cycle the block reads the channel's configuration and the selected link's data, and it registers the assembled byte. One cycle later the byte appears with a single-cycle valid pulse and the channel index. The configuration is read only on that strobe, so every byte is built from one consistent setting.

Top module: `trib_sig_byte_ins`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0, `out_ch` is 0 and `out_byte` is 0 until the first accepted strobe.
- R2: A strobe with `strb_ch` below NCH while `bsync_mode` is 1 produces `out_valid`=1 in the next cycle only, with `out_ch` equal to the strobed index.
- R3: A strobe while `bsync_mode` is 0, or a strobe with `strb_ch` of NCH or more, produces no valid pulse and leaves `out_byte` and `out_ch` unchanged.
- R4: Bit 0 (R position) of every output byte equals `stuff_dflt` as sampled in the strobe cycle.
- R5: Bits 7:6 (P1, P0) equal the selected link's `link_p` pair (pair bit 1 is P1) when the channel's `use_p` is 1. Otherwise both bits equal `oh_dflt`.
- R6: Bits 5:2 (S1..S4) equal the selected link's `link_s` nibble (nibble bit 3 is S1, at output bit 5) when the channel's `use_s` is 1. Otherwise all four bits equal `oh_dflt`.
- R7: Bit 1 (F position) equals the selected link's `link_f` bit when the channel's `use_f` is 1. Otherwise it equals `oh_dflt`.
- R8: A channel selector value of NLINK (28) or more selects no link. Bits 7:1 then all equal `oh_dflt`, whatever the use flags are.
- R9: The byte is built only from the inputs present in the strobe cycle. Without a valid pulse, `out_byte` holds its last value, even when the configuration or the link data change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bsync_mode | input | 1 | Byte-synchronous mode enable |
| strb | input | 1 | Byte-boundary strobe |
| strb_ch | input | 5 | Channel index for the strobe |
| ch_sel | input | NCH*5 | Link selector for each channel, channel c at [c*5 +: 5] |
| use_p | input | NCH | Phase-use flag for each channel |
| use_s | input | NCH | Signaling-use flag for each channel |
| use_f | input | NCH | Frame-bit-use flag for each channel |
| oh_dflt | input | 1 | Overhead default value for unused positions |
| stuff_dflt | input | 1 | Fixed-stuff value for the R position |
| link_p | input | NLINK*2 | Phase pair for each link, link k at [k*2 +: 2] |
| link_s | input | NLINK*4 | Signaling nibble for each link, link k at [k*4 +: 4] |
| link_f | input | NLINK | Frame bit for each link |
| out_valid | output | 1 | One-cycle valid for the assembled byte |
| out_ch | output | 5 | Channel index of the assembled byte |
| out_byte | output | 8 | Assembled byte P1 P0 S1 S2 S3 S4 F R |

## Verification
Two events can fall in the same cycle: a strobe for a channel, and a change to that channel's configuration or to the mode. The bench changes the use flags, the selector and the link data in the cycle that follows a strobe, and again while no strobe is present. It then checks that the registered byte matches a model evaluated only on the strobe-cycle values, and that the byte holds between strobes. It also drops `bsync_mode`, and sends out-of-range indices, in cycles that carry a strobe. In those cases it checks that no valid pulse appears and that the previous byte survives.

// File: rtl/trib_sig_byte_ins.sv
module trib_sig_byte_ins #(
  parameter int NCH   = 28,
  parameter int NLINK = 28,
  parameter int SELW  = 5,
  parameter int CHW   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bsync_mode,
  input  logic                strb,
  input  logic [CHW-1:0]      strb_ch,
  input  logic [NCH*SELW-1:0] ch_sel,
  input  logic [NCH-1:0]      use_p,
  input  logic [NCH-1:0]      use_s,
  input  logic [NCH-1:0]      use_f,
  input  logic                oh_dflt,
  input  logic                stuff_dflt,
  input  logic [NLINK*2-1:0]  link_p,
  input  logic [NLINK*4-1:0]  link_s,
  input  logic [NLINK-1:0]    link_f,
  output logic                out_valid,
  output logic [CHW-1:0]      out_ch,
  output logic [7:0]          out_byte
);

  logic           ch_ok, take, linked;
  logic [CHW-1:0] ch;
  logic [SELW-1:0] sel, lk;
  logic [1:0]     ph;
  logic [3:0]     sg;
  logic           fb;
  logic [7:0]     asm_byte;

  assign ch_ok  = 32'(strb_ch) < NCH;
  assign take   = strb && bsync_mode && ch_ok;
  assign ch     = ch_ok ? strb_ch : '0;
  assign sel    = ch_sel[32'(ch)*SELW +: SELW];
  assign linked = 32'(sel) < NLINK;
  assign lk     = linked ? sel : '0;

  assign ph = (linked && use_p[ch]) ? link_p[32'(lk)*2 +: 2] : {2{oh_dflt}};
  assign sg = (linked && use_s[ch]) ? link_s[32'(lk)*4 +: 4] : {4{oh_dflt}};
  assign fb = (linked && use_f[ch]) ? link_f[lk]             : oh_dflt;

  assign asm_byte = {ph, sg, fb, stuff_dflt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_byte  <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_ch   <= strb_ch;
        out_byte <= asm_byte;
      end
    end
  end

  a_r2_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && bsync_mode && 32'(strb_ch) < NCH) |=> (out_valid && out_ch == $past(strb_ch)));

  a_r3_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!bsync_mode || !strb) |=> !out_valid);

  a_r4_stuff_bit: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_byte[0] == $past(stuff_dflt));

  a_r8_no_link_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !linked) |=> out_byte[7:1] == {7{$past(oh_dflt)}});

  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(out_byte) && $stable(out_ch));

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_byte == 8'h00 && out_ch == '0));

endmodule

// File: tb/trib_sig_byte_ins_test.sv
module trib_sig_byte_ins_test;
  localparam int NCH = 28, NLINK = 28, SELW = 5, CHW = 5;

  logic clk = 0, rst_n = 0;
  logic bsync_mode = 0, strb = 0, oh_dflt = 0, stuff_dflt = 0;
  logic [CHW-1:0] strb_ch = '0;
  logic [NCH*SELW-1:0] ch_sel = '0;
  logic [NCH-1:0] use_p = '0, use_s = '0, use_f = '0;
  logic [NLINK*2-1:0] link_p = '0;
  logic [NLINK*4-1:0] link_s = '0;
  logic [NLINK-1:0] link_f = '0;
  logic out_valid;
  logic [CHW-1:0] out_ch;
  logic [7:0] out_byte;

  int checks = 0, errors = 0;
  logic [7:0] last_byte = 8'h00;
  logic [CHW-1:0] last_ch = '0;

  trib_sig_byte_ins #(.NCH(NCH), .NLINK(NLINK), .SELW(SELW), .CHW(CHW)) uut (
    .clk(clk), .rst_n(rst_n), .bsync_mode(bsync_mode), .strb(strb), .strb_ch(strb_ch),
    .ch_sel(ch_sel), .use_p(use_p), .use_s(use_s), .use_f(use_f),
    .oh_dflt(oh_dflt), .stuff_dflt(stuff_dflt),
    .link_p(link_p), .link_s(link_s), .link_f(link_f),
    .out_valid(out_valid), .out_ch(out_ch), .out_byte(out_byte));

  always #4 clk = ~clk;

  function automatic logic [7:0] model(input int c);
    logic [4:0] s;
    logic [1:0] p;
    logic [3:0] g;
    logic f;
    s = ch_sel[c*SELW +: SELW];
    p = {2{oh_dflt}}; g = {4{oh_dflt}}; f = oh_dflt;
    if (int'(s) < NLINK) begin
      if (use_p[c]) p = link_p[int'(s)*2 +: 2];
      if (use_s[c]) g = link_s[int'(s)*4 +: 4];
      if (use_f[c]) f = link_f[int'(s)];
    end
    return {p, g, f, stuff_dflt};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic randomize_cfg();
    for (int i = 0; i < NCH; i++) begin
      ch_sel[i*SELW +: SELW] = 5'($urandom);
      use_p[i] = 1'($urandom); use_s[i] = 1'($urandom); use_f[i] = 1'($urandom);
    end
    link_p = '0; link_s = '0; link_f = '0;
    for (int k = 0; k < NLINK; k++) begin
      link_p[k*2 +: 2] = 2'($urandom);
      link_s[k*4 +: 4] = 4'($urandom);
      link_f[k] = 1'($urandom);
    end
    oh_dflt = 1'($urandom); stuff_dflt = 1'($urandom);
  endtask

  // drive at negedge, evaluate one edge, check at next negedge
  task automatic step(input bit s, input int c, input bit mode, input bit scramble);
    bit accept;
    logic [7:0] exp_b;
    strb = s; strb_ch = CHW'(c); bsync_mode = mode;
    accept = s && mode && c < NCH;
    exp_b = accept ? model(c) : last_byte;
    @(posedge clk);
    #1;
    strb = 0;
    if (scramble) randomize_cfg();
    @(negedge clk);
    if (accept) begin
      chk(out_valid === 1'b1, "R2 valid", int'(out_valid), 1);
      chk(out_ch === CHW'(c), "R2 channel", int'(out_ch), c);
      chk(out_byte[0] === exp_b[0], "R4 stuff bit", int'(out_byte[0]), int'(exp_b[0]));
      chk(out_byte[7:6] === exp_b[7:6], "R5 phase", int'(out_byte[7:6]), int'(exp_b[7:6]));
      chk(out_byte[5:2] === exp_b[5:2], "R6 signaling", int'(out_byte[5:2]), int'(exp_b[5:2]));
      chk(out_byte[1] === exp_b[1], "R7 frame bit", int'(out_byte[1]), int'(exp_b[1]));
      last_ch = CHW'(c);
    end else begin
      chk(out_valid === 1'b0, "R3 no pulse", int'(out_valid), 0);
      chk(out_byte === last_byte && out_ch === last_ch, "R3/R9 hold",
          int'(out_byte), int'(last_byte));
    end
    last_byte = exp_b;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7411));
    randomize_cfg();
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_byte === 8'h00 && out_ch === '0, "R1 reset", int'(out_byte), 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid === 1'b0 && out_byte === 8'h00, "R1 after release", int'(out_byte), 0);

    // directed R8: selector at 28 and 31, all use flags set
    ch_sel[3*SELW +: SELW] = 5'd28; use_p[3] = 1; use_s[3] = 1; use_f[3] = 1;
    oh_dflt = 1; stuff_dflt = 0;
    step(1, 3, 1, 0);
    chk(out_byte === 8'hFE, "R8 selector 28", int'(out_byte), 8'hFE);
    ch_sel[3*SELW +: SELW] = 5'd31; oh_dflt = 0; stuff_dflt = 1;
    step(1, 3, 1, 0);
    chk(out_byte === 8'h01, "R8 selector 31", int'(out_byte), 8'h01);

    // directed R5-R7: live link 27 with all flags, then all flags clear
    ch_sel[0 +: SELW] = 5'd27; use_p[0] = 1; use_s[0] = 1; use_f[0] = 1;
    link_p[54 +: 2] = 2'b10; link_s[108 +: 4] = 4'b1001; link_f[27] = 1; oh_dflt = 0; stuff_dflt = 0;
    step(1, 0, 1, 0);
    chk(out_byte === 8'b10_1001_1_0, "R6 live fields", int'(out_byte), 8'hA6);
    use_p[0] = 0; use_s[0] = 0; use_f[0] = 0; oh_dflt = 1;
    step(1, 0, 1, 0);
    chk(out_byte === 8'hFE, "R5 defaults", int'(out_byte), 8'hFE);

    // R3: mode off with strobe, out-of-range channel, R9: idle with scrambling
    step(1, 5, 0, 1);
    step(1, 28, 1, 1);
    step(1, 31, 1, 0);
    step(0, 0, 1, 1);
    step(0, 0, 1, 1);

    // random mix, config scrambled right after the strobe edge
    for (int n = 0; n < 400; n++) begin
      step(($urandom % 8) != 0, int'($urandom % 32), ($urandom % 10) != 0, ($urandom % 2) == 1);
    end
    // back-to-back strobes on last channel
    for (int n = 0; n < 4; n++) step(1, NCH - 1, 1, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule